// File: doc/BRIEF.md
# Real-Time Clock Register Access Front End

This block sits between a serial bus engine and the counters of a real-time clock. The bus engine decodes framing and byte traffic into single-cycle events: bus start, bus stop, pointer load (with the new address), byte read and byte write. The block holds the register pointer, presents the byte the pointer selects, and moves the pointer forward by one after every data byte. It also holds the control, trickle-charge and flag registers, and it forwards writes to the time counters as a one-cycle strobe with address and data.

Reads of the seven time bytes do not come from the live counters. They come from a private seven-byte copy. This copy is refreshed at bus start, at bus stop and whenever the pointer steps around to address 0. A multibyte read therefore sees one consistent instant while the counters keep running. Auto-increment runs over the clock and control space (0 to 7) and wraps to 0. The trickle and flag registers at 8 and 9 are reached only by loading the pointer with that address.

The bus engine is expected to raise at most one of pointer load, byte read and byte write in a cycle. If it raises more, pointer load wins and the byte event is dropped.

Top module: `rtc_reg_front`

## Requirements
- R1: A synchronous reset sets the pointer to 0 and clears the control register, the trickle register, the oscillator-stop flag and the time copy. After reset, addresses 0, 7, 8 and 9 all read 00h.
- R2: A pointer load with a value from 0 to 9 sets the pointer to that value. A load with any value above 9 sets the pointer to 0. Neither kind of load refreshes the time copy.
- R3: Each byte read or byte write without a pointer load advances the pointer by one across addresses 0 to 6. From address 7 the pointer goes to 0.
- R4: A byte access at address 8 moves the pointer to 9, and a byte access at address 9 moves it to 0.
- R5: On the clock edge of a bus start, a bus stop, or a byte access that moves the pointer from 7 or 9 to 0, all seven live time bytes are copied into the time copy. The copy is readable in the next cycle. At all other times the copy holds its value while the live bytes change. Live byte k is bits 8k+7 down to 8k of the live-time input.
- R6: While the pointer is at 0 to 6, rdData combinationally shows byte k of the time copy, where k is the pointer. It never shows the live input.
- R7: A byte write at address 0 to 6 raises timeWrEn for exactly the next cycle, with timeWrAddr equal to the address and timeWrData equal to the byte. It does not alter the time copy. Writes at 7 to 9 raise no strobe.
- R8: A byte write at address 7 loads the control register and one at address 8 loads the trickle register. Both appear on their output ports from the next cycle and read back at their address.
- R9: Address 9 reads with bit 7 as the oscillator-stop flag and bits 6 to 0 as 0. The flag is set by oscStopIn, which takes priority over a write. Otherwise it takes bit 7 of a byte written at address 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evStart | input | 1 | Bus start seen, one cycle |
| evStop | input | 1 | Bus stop seen, one cycle |
| ptrLoad | input | 1 | Load pointer from ptrData |
| ptrData | input | 8 | New pointer value |
| rdByte | input | 1 | Data byte read completed, advance pointer |
| wrByte | input | 1 | Data byte written at pointer |
| wrData | input | 8 | Byte being written |
| liveTime | input | 56 | Live time counters, byte k at bits 8k+7:8k |
| oscStopIn | input | 1 | Oscillator stop detected, sets flag |
| rdData | output | 8 | Byte at the current pointer |
| timeWrEn | output | 1 | One-cycle write strobe to time counters |
| timeWrAddr | output | 3 | Time byte index for the strobe |
| timeWrData | output | 8 | Data for the strobe |
| ctrlReg | output | 8 | Control register contents |
| trickleReg | output | 8 | Trickle-charge register contents |

## Verification
The directed part of the test sends the reset state, loads of 7, 8, 9 and out-of-range values, and full write passes through the control and trickle registers. The pointer walk and wrap are seen through rdData, because every register holds a different value. A read burst is sent after a bus start while the live time changes every cycle. A byte read while the live input differs from the copy separates a correct copy path from a design that reads the live input. A refresh that follows a wrap but does not follow a pointer load separates the two causes of pointer movement. Constrained random mixes of all events, with writes that set and clear the flag, then check rdData, the strobe and the register outputs after every cycle against a reference model.

// File: rtl/rtcfe_pkg.sv
package rtcfe_pkg;
  localparam int BYTE_W     = 8;
  localparam int TIME_BYTES = 7;
  localparam int REG_COUNT  = 10;
  localparam int ADDR_W     = $clog2(REG_COUNT);
  localparam int TADDR_W    = $clog2(TIME_BYTES);
  localparam int TIME_W     = TIME_BYTES * BYTE_W;

  typedef logic [ADDR_W-1:0] regAddr_t;

  localparam regAddr_t ADDR_CTRL    = regAddr_t'(TIME_BYTES);
  localparam regAddr_t ADDR_TRICKLE = regAddr_t'(TIME_BYTES + 1);
  localparam regAddr_t ADDR_FLAG    = regAddr_t'(TIME_BYTES + 2);
  localparam regAddr_t ADDR_TLIMIT  = regAddr_t'(TIME_BYTES);
  localparam logic [BYTE_W-1:0] LAST_REG = BYTE_W'(REG_COUNT - 1);

  // strobes from control to datapath
  typedef struct packed {
    logic     snapTake;
    logic     regWrite;
    logic     timeWrite;
    regAddr_t addr;
  } ctrlStrobe_t;
endpackage

// File: rtl/rtcfe_ctrl.sv
module rtcfe_ctrl
  import rtcfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              evStart,
  input  logic              evStop,
  input  logic              ptrLoad,
  input  logic [BYTE_W-1:0] ptrData,
  input  logic              rdByte,
  input  logic              wrByte,
  output ctrlStrobe_t       stb
);
  regAddr_t ptrQ;
  regAddr_t loadVal;
  regAddr_t incVal;
  logic     access;
  logic     atWrapPoint;

  assign access      = (rdByte || wrByte) && !ptrLoad;
  assign atWrapPoint = (ptrQ == ADDR_CTRL) || (ptrQ == ADDR_FLAG);
  assign loadVal     = (ptrData > LAST_REG) ? '0 : ptrData[ADDR_W-1:0];
  assign incVal      = atWrapPoint ? '0 : ptrQ + regAddr_t'(1);

  always_ff @(posedge clk) begin
    if (rst)          ptrQ <= '0;
    else if (ptrLoad) ptrQ <= loadVal;
    else if (access)  ptrQ <= incVal;
  end

  always_comb begin
    stb.addr      = ptrQ;
    stb.regWrite  = wrByte && !ptrLoad;
    stb.timeWrite = wrByte && !ptrLoad && (ptrQ < ADDR_TLIMIT);
    stb.snapTake  = evStart || evStop || (access && atWrapPoint);
  end
endmodule

// File: rtl/rtcfe_dpath.sv
module rtcfe_dpath
  import rtcfe_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobe_t        stb,
  input  logic [TIME_W-1:0]  liveTime,
  input  logic [BYTE_W-1:0]  wrData,
  input  logic               oscStopIn,
  output logic [BYTE_W-1:0]  rdData,
  output logic               timeWrEn,
  output logic [TADDR_W-1:0] timeWrAddr,
  output logic [BYTE_W-1:0]  timeWrData,
  output logic [BYTE_W-1:0]  ctrlReg,
  output logic [BYTE_W-1:0]  trickleReg,
  output logic [TIME_W-1:0]  snapAll
);
  logic [BYTE_W-1:0] snapArr [TIME_BYTES];
  logic              oscFlag;

  for (genvar g = 0; g < TIME_BYTES; g++) begin : gSnap
    always_ff @(posedge clk) begin
      if (rst)               snapArr[g] <= '0;
      else if (stb.snapTake) snapArr[g] <= liveTime[g*BYTE_W +: BYTE_W];
    end
    assign snapAll[g*BYTE_W +: BYTE_W] = snapArr[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timeWrEn   <= 1'b0;
      timeWrAddr <= '0;
      timeWrData <= '0;
    end else begin
      timeWrEn <= stb.timeWrite;
      if (stb.timeWrite) begin
        timeWrAddr <= stb.addr[TADDR_W-1:0];
        timeWrData <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg    <= '0;
      trickleReg <= '0;
      oscFlag    <= 1'b0;
    end else begin
      if (stb.regWrite && stb.addr == ADDR_CTRL)    ctrlReg    <= wrData;
      if (stb.regWrite && stb.addr == ADDR_TRICKLE) trickleReg <= wrData;
      if (oscStopIn)                                oscFlag    <= 1'b1;
      else if (stb.regWrite && stb.addr == ADDR_FLAG) oscFlag  <= wrData[BYTE_W-1];
    end
  end

  always_comb begin
    rdData = '0;
    if (stb.addr < ADDR_TLIMIT) rdData = snapArr[stb.addr[TADDR_W-1:0]];
    else begin
      case (stb.addr)
        ADDR_CTRL:    rdData = ctrlReg;
        ADDR_TRICKLE: rdData = trickleReg;
        ADDR_FLAG:    rdData = {oscFlag, {(BYTE_W-1){1'b0}}};
        default:      rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_reg_front.sv
module rtc_reg_front
  import rtcfe_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               evStart,
  input  logic               evStop,
  input  logic               ptrLoad,
  input  logic [BYTE_W-1:0]  ptrData,
  input  logic               rdByte,
  input  logic               wrByte,
  input  logic [BYTE_W-1:0]  wrData,
  input  logic [TIME_W-1:0]  liveTime,
  input  logic               oscStopIn,
  output logic [BYTE_W-1:0]  rdData,
  output logic               timeWrEn,
  output logic [TADDR_W-1:0] timeWrAddr,
  output logic [BYTE_W-1:0]  timeWrData,
  output logic [BYTE_W-1:0]  ctrlReg,
  output logic [BYTE_W-1:0]  trickleReg
);
  ctrlStrobe_t       stb;
  logic [TIME_W-1:0] snapAll;

  rtcfe_ctrl u_ctrl (
    .clk(clk), .rst(rst), .evStart(evStart), .evStop(evStop),
    .ptrLoad(ptrLoad), .ptrData(ptrData), .rdByte(rdByte),
    .wrByte(wrByte), .stb(stb)
  );

  rtcfe_dpath u_dpath (
    .clk(clk), .rst(rst), .stb(stb), .liveTime(liveTime),
    .wrData(wrData), .oscStopIn(oscStopIn), .rdData(rdData),
    .timeWrEn(timeWrEn), .timeWrAddr(timeWrAddr), .timeWrData(timeWrData),
    .ctrlReg(ctrlReg), .trickleReg(trickleReg), .snapAll(snapAll)
  );
endmodule

// File: rtl/rtcfe_chk.sv
module rtcfe_chk
  import rtcfe_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               evStart,
  input logic               evStop,
  input logic               ptrLoad,
  input logic [BYTE_W-1:0]  ptrData,
  input logic               rdByte,
  input logic               wrByte,
  input logic [BYTE_W-1:0]  wrData,
  input logic [BYTE_W-1:0]  rdData,
  input logic               timeWrEn,
  input logic [TADDR_W-1:0] timeWrAddr,
  input logic [BYTE_W-1:0]  timeWrData,
  input logic [BYTE_W-1:0]  ctrlReg,
  input logic [BYTE_W-1:0]  trickleReg,
  input regAddr_t           ptrCur,
  input logic [TIME_W-1:0]  snapAll
);
  logic byteAcc;
  logic refresh;
  assign byteAcc = (rdByte || wrByte) && !ptrLoad;
  assign refresh = evStart || evStop ||
                   (byteAcc && (ptrCur == ADDR_CTRL || ptrCur == ADDR_FLAG));

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) && !rst |-> ptrCur == '0 && ctrlReg == '0 && trickleReg == '0);

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    ptrLoad && ptrData <= LAST_REG |=> ptrCur == $past(ptrData[ADDR_W-1:0]));

  p_load_high_r2: assert property (@(posedge clk) disable iff (rst)
    ptrLoad && ptrData > LAST_REG |=> ptrCur == '0);

  p_wrap_ctrl_r3: assert property (@(posedge clk) disable iff (rst)
    byteAcc && ptrCur == ADDR_CTRL |=> ptrCur == '0);

  p_wrap_flag_r4: assert property (@(posedge clk) disable iff (rst)
    byteAcc && ptrCur == ADDR_FLAG |=> ptrCur == '0);

  p_snap_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !refresh |=> $stable(snapAll));

  p_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    wrByte && !ptrLoad && ptrCur < ADDR_TLIMIT |=>
      timeWrEn && timeWrAddr == $past(ptrCur[TADDR_W-1:0]) && timeWrData == $past(wrData));

  p_no_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    !(wrByte && !ptrLoad && ptrCur < ADDR_TLIMIT) |=> !timeWrEn);

  p_ctrl_write_r8: assert property (@(posedge clk) disable iff (rst)
    wrByte && !ptrLoad && ptrCur == ADDR_CTRL |=> ctrlReg == $past(wrData));

  p_flag_zero_r9: assert property (@(posedge clk) disable iff (rst)
    ptrCur == ADDR_FLAG |-> rdData[BYTE_W-2:0] == '0);
endmodule

bind rtc_reg_front rtcfe_chk u_chk (
  .clk(clk), .rst(rst), .evStart(evStart), .evStop(evStop),
  .ptrLoad(ptrLoad), .ptrData(ptrData), .rdByte(rdByte), .wrByte(wrByte),
  .wrData(wrData), .rdData(rdData), .timeWrEn(timeWrEn),
  .timeWrAddr(timeWrAddr), .timeWrData(timeWrData), .ctrlReg(ctrlReg),
  .trickleReg(trickleReg), .ptrCur(stb.addr), .snapAll(snapAll)
);

// File: tb/tb_rtc_reg_front.sv
module tb_rtc_reg_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evStart = 0, evStop = 0, ptrLoad = 0, rdByte = 0, wrByte = 0, oscStopIn = 0;
  logic [7:0]  ptrData = '0, wrData = '0;
  logic [55:0] liveTime = '0;
  logic [7:0]  rdData, timeWrData, ctrlReg, trickleReg;
  logic        timeWrEn;
  logic [2:0]  timeWrAddr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference model state
  int          mPtr;
  logic [7:0]  mSnap [7];
  logic [7:0]  mCtrl, mTrk;
  logic        mOsf;
  logic        eWrEn;
  logic [2:0]  eWrAddr;
  logic [7:0]  eWrData;

  always #2.5 clk = ~clk;

  rtc_reg_front dut (
    .clk(clk), .rst(rst), .evStart(evStart), .evStop(evStop),
    .ptrLoad(ptrLoad), .ptrData(ptrData), .rdByte(rdByte), .wrByte(wrByte),
    .wrData(wrData), .liveTime(liveTime), .oscStopIn(oscStopIn),
    .rdData(rdData), .timeWrEn(timeWrEn), .timeWrAddr(timeWrAddr),
    .timeWrData(timeWrData), .ctrlReg(ctrlReg), .trickleReg(trickleReg)
  );

  function automatic logic [7:0] expRead(int p);
    if (p < 7) return mSnap[p];
    if (p == 7) return mCtrl;
    if (p == 8) return mTrk;
    if (p == 9) return {mOsf, 7'b0};
    return 8'h00;
  endfunction

  function automatic int nextPtr(int p);
    if (p == 7 || p == 9) return 0;
    return p + 1;
  endfunction

  function automatic string regionTag(int p);
    if (p < 7) return "R6";
    if (p == 9) return "R9";
    return "R8";
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    chk({tag, "/", regionTag(mPtr)}, "rdData", 64'(rdData), 64'(expRead(mPtr)));
    chk({tag, "/R7"}, "timeWrEn", 64'(timeWrEn), 64'(eWrEn));
    if (eWrEn) begin
      chk({tag, "/R7"}, "timeWrAddr", 64'(timeWrAddr), 64'(eWrAddr));
      chk({tag, "/R7"}, "timeWrData", 64'(timeWrData), 64'(eWrData));
    end
    chk({tag, "/R8"}, "ctrlReg", 64'(ctrlReg), 64'(mCtrl));
    chk({tag, "/R8"}, "trickleReg", 64'(trickleReg), 64'(mTrk));
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(input bit s, input bit p, input bit l, input logic [7:0] lv,
                      input bit r, input bit w, input logic [7:0] wd, input bit o,
                      input string tag);
    logic [55:0] lt;
    bit acc;
    lt = {$urandom, $urandom};
    evStart = s; evStop = p; ptrLoad = l; ptrData = lv;
    rdByte = r; wrByte = w; wrData = wd; oscStopIn = o; liveTime = lt;
    @(posedge clk);
    acc = (r || w) && !l;
    eWrEn = w && !l && mPtr < 7;
    if (eWrEn) begin eWrAddr = 3'(mPtr); eWrData = wd; end
    if (s || p || (acc && (mPtr == 7 || mPtr == 9)))
      for (int k = 0; k < 7; k++) mSnap[k] = lt[k*8 +: 8];
    if (w && !l) begin
      if (mPtr == 7) mCtrl = wd;
      if (mPtr == 8) mTrk = wd;
      if (mPtr == 9) mOsf = wd[7];
    end
    if (o) mOsf = 1'b1;
    if (l) mPtr = (lv > 9) ? 0 : int'(lv);
    else if (acc) mPtr = nextPtr(mPtr);
    @(negedge clk);
    evStart = 0; evStop = 0; ptrLoad = 0; rdByte = 0; wrByte = 0; oscStopIn = 0;
    checkAll(tag);
  endtask

  task automatic ld(input logic [7:0] v, input string tag);
    step(0, 0, 1, v, 0, 0, 8'h00, 0, tag);
  endtask
  task automatic rd(input string tag);
    step(0, 0, 0, 8'h00, 1, 0, 8'h00, 0, tag);
  endtask
  task automatic wr(input logic [7:0] d, input string tag);
    step(0, 0, 0, 8'h00, 0, 1, d, 0, tag);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    mPtr = 0; mCtrl = 0; mTrk = 0; mOsf = 0; eWrEn = 0; eWrAddr = 0; eWrData = 0;
    for (int k = 0; k < 7; k++) mSnap[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    checkAll("R1");
    ld(8'd7, "R1"); ld(8'd8, "R1"); ld(8'd9, "R1");
    // R8: control and trickle writes; R4: 8 -> 9 -> 0 with flag write
    ld(8'd7, "R8"); wr(8'hA5, "R8");          // wrap at 7 also refreshes copy (R5)
    ld(8'd8, "R4"); wr(8'h3C, "R4"); wr(8'h80, "R4");
    ld(8'd9, "R9"); wr(8'h7F, "R9");          // clears flag, low bits ignored
    ld(8'd9, "R9");
    step(0, 0, 0, 8'h00, 0, 0, 8'h00, 1, "R9");  // oscillator stop sets flag
    step(0, 0, 0, 8'h00, 0, 1, 8'h00, 1, "R9");  // set wins over write of 0
    // R2: out-of-range loads
    ld(8'd5, "R2"); ld(8'h0C, "R2"); ld(8'd5, "R2"); ld(8'hFF, "R2");
    // R5/R6: start then read burst through wrap at 7 (R3)
    step(1, 0, 0, 8'h00, 0, 0, 8'h00, 0, "R5");
    for (int i = 0; i < 9; i++) rd("R3");
    step(0, 1, 0, 8'h00, 0, 0, 8'h00, 0, "R5");
    ld(8'd0, "R2");                            // load of 0 is no refresh
    rd("R6");
    // R7: write all time bytes, copy unchanged
    ld(8'd0, "R7");
    for (int i = 0; i < 7; i++) wr(8'(8'h10 + i), "R7");
    wr(8'h55, "R7");                          // address 7: no strobe
    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom % 16);
      case (op)
        0:        step(1, 0, 0, 8'h00, 0, 0, 8'h00, 0, "R5");
        1:        step(0, 1, 0, 8'h00, 0, 0, 8'h00, 0, "R5");
        2, 3:     ld(8'($urandom % 12), "R2");
        4, 5, 6, 7, 8: rd("R3");
        9, 10, 11, 12: wr(8'($urandom), "R7");
        13:       step(0, 0, 0, 8'h00, 0, 0, 8'h00, 1, "R9");
        default:  step(0, 0, 0, 8'h00, 0, 0, 8'h00, 0, "R6");
      endcase
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule